// File: doc/BRIEF.md
# Handshaked Sequential Adder

This block adds two unsigned operands through a short fixed sequence. A requester holds `go_req` high while the unit is idle. The unit then latches both operands in a capture step, loads their sum into a result register in a separate sum step, and returns to idle. While it is idle the unit raises `ready_out`. The result stays on `sum_out` until the next sum step overwrites it.

The design has two halves. A control sequencer has three named states: `ST_IDLE`, `ST_CAPTURE` and `ST_SUM`. A data path holds the operand registers, the result register and one adder. The sequencer reaches the data path only through two load enables: one for both operands and one for the result. Every register uses clear-over-load priority, with synchronous reset as the clear.

The sequencer has four transitions. `ST_IDLE` goes to `ST_IDLE` while `go_req` is low. `ST_IDLE` goes to `ST_CAPTURE` when `go_req` is high. `ST_CAPTURE` always goes to `ST_SUM`. `ST_SUM` always goes to `ST_IDLE`. Each operation therefore takes exactly three clock cycles.

Top module: `seq_add_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the unit enters `ST_IDLE` and clears both operand registers and the result. On the cycle that follows, `ready_out` is 1 and `sum_out` is 0.
- R2: In `ST_IDLE` with `go_req` low, the unit stays idle, so `ready_out` remains 1.
- R3: In `ST_IDLE` with `go_req` high, the unit moves to `ST_CAPTURE` at the next edge, and `ready_out` reads 0 in that cycle.
- R4: Operands are sampled only at the edge that ends `ST_CAPTURE`. Values on `opa_in`/`opb_in` in any other cycle, including the request cycle and the `ST_SUM` cycle, do not affect the result.
- R5: `sum_out` is loaded with (A + B) mod 2^DATA_W at the edge that ends `ST_SUM`, and the carry out of the top bit is dropped.
- R6: `ready_out` is 0 for exactly two cycles per operation (`ST_CAPTURE`, `ST_SUM`) and returns to 1 on the third cycle after the request edge.
- R7: `sum_out` does not change while `ready_out` stays high, whatever the operand inputs do.
- R8: If `go_req` is still high when the unit returns to `ST_IDLE`, a new operation starts at once. `ready_out` is then high for a single cycle.
- R9: A reset asserted in mid-operation abandons it. The unit comes back idle with `sum_out` equal to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset (register clear) |
| go_req | input | 1 | Request to start an addition |
| opa_in | input | DATA_W | First operand, sampled in `ST_CAPTURE` |
| opb_in | input | DATA_W | Second operand, sampled in `ST_CAPTURE` |
| sum_out | output | DATA_W | Registered sum of the last completed operation |
| ready_out | output | 1 | High while the unit is idle |

## Verification
The adder is swept with boundary pairs and about a thousand arithmetic operand patterns. The boundary pairs are zero, all ones, the top-bit-only value and their wrap-around sums. Wrap-around sums separate a correct modulo add from one that keeps or misplaces the carry. Decoy values are placed on the operand inputs in the request cycle and the sum cycle, and only the capture-cycle values may reach the result; this exposes a capture step enabled in the wrong state. Further cases separate a sequencer that skips or repeats a state from a correct one: idle stretches with changing inputs, back-to-back requests with `go_req` held, and a reset in mid-operation.

// File: rtl/seq_add_pkg.sv
package seq_add_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_CAPTURE = 2'd1,
        ST_SUM     = 2'd2
    } sa_state_t;
endpackage

// File: rtl/sa_reg.sv
module sa_reg #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             ld,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    // clear wins over load; otherwise hold
    always_ff @(posedge clk) begin
        if (clr)
            q <= '0;
        else if (ld)
            q <= d;
    end
endmodule

// File: rtl/sa_ctrl.sv
module sa_ctrl
    import seq_add_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic go_req,
    output logic ld_opnd,
    output logic ld_sum,
    output logic ready
);
    sa_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    state_d = go_req ? ST_CAPTURE : ST_IDLE;
            ST_CAPTURE: state_d = ST_SUM;
            ST_SUM:     state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        ld_opnd = 1'b0;
        ld_sum  = 1'b0;
        ready   = 1'b0;
        unique case (state_q)
            ST_IDLE:    ready   = 1'b1;
            ST_CAPTURE: ld_opnd = 1'b1;
            ST_SUM:     ld_sum  = 1'b1;
            default:    ready   = 1'b0;
        endcase
    end
endmodule

// File: rtl/sa_datapath.sv
module sa_datapath #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              clr,
    input  logic              ld_opnd,
    input  logic              ld_sum,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output logic [DATA_W-1:0] sum
);
    localparam int NUM_OPND = 2;

    logic [DATA_W-1:0] opnd_d [NUM_OPND];
    logic [DATA_W-1:0] opnd_q [NUM_OPND];
    logic [DATA_W-1:0] add_res;

    assign opnd_d[0] = opa;
    assign opnd_d[1] = opb;

    for (genvar i = 0; i < NUM_OPND; i++) begin : g_opnd
        sa_reg #(.WIDTH(DATA_W)) u_opnd (
            .clk (clk),
            .clr (clr),
            .ld  (ld_opnd),
            .d   (opnd_d[i]),
            .q   (opnd_q[i])
        );
    end

    // width-truncated add: carry out of the top bit is discarded
    assign add_res = opnd_q[0] + opnd_q[1];

    sa_reg #(.WIDTH(DATA_W)) u_res (
        .clk (clk),
        .clr (clr),
        .ld  (ld_sum),
        .d   (add_res),
        .q   (sum)
    );
endmodule

// File: rtl/seq_add_unit.sv
module seq_add_unit #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go_req,
    input  logic [DATA_W-1:0] opa_in,
    input  logic [DATA_W-1:0] opb_in,
    output logic [DATA_W-1:0] sum_out,
    output logic              ready_out
);
    logic ld_opnd, ld_sum;

    sa_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .go_req  (go_req),
        .ld_opnd (ld_opnd),
        .ld_sum  (ld_sum),
        .ready   (ready_out)
    );

    sa_datapath #(.DATA_W(DATA_W)) u_dp (
        .clk     (clk),
        .clr     (rst),
        .ld_opnd (ld_opnd),
        .ld_sum  (ld_sum),
        .opa     (opa_in),
        .opb     (opb_in),
        .sum     (sum_out)
    );
endmodule

// File: rtl/seq_add_chk.sv
module seq_add_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              go_req,
    input logic [DATA_W-1:0] opa_in,
    input logic [DATA_W-1:0] opb_in,
    input logic [DATA_W-1:0] sum_out,
    input logic              ready_out
);
    logic rst_q;
    always_ff @(posedge clk) rst_q <= rst;

    // R1, R9: the cycle after a reset edge is idle with a cleared result
    a_r1_reset_state: assert property (@(posedge clk)
        (rst_q === 1'b1) |-> (ready_out && sum_out == '0));

    // R2: idle without a request stays idle
    a_r2_idle_holds: assert property (@(posedge clk) disable iff (rst)
        (ready_out && !go_req) |=> ready_out);

    // R3: a request leaves idle at the next edge
    a_r3_start_leaves_idle: assert property (@(posedge clk) disable iff (rst)
        (ready_out && go_req) |=> !ready_out);

    // R6: after falling, ready stays low for one more cycle
    a_r6_busy_two: assert property (@(posedge clk) disable iff (rst)
        $fell(ready_out) |=> !ready_out);

    // R6: two busy cycles are always followed by idle
    a_r6_busy_ends: assert property (@(posedge clk) disable iff (rst)
        (!ready_out && $past(!ready_out)) |=> ready_out);

    // R7: result steady across consecutive idle cycles
    a_r7_result_holds: assert property (@(posedge clk) disable iff (rst)
        (ready_out && $past(ready_out)) |-> $stable(sum_out));

    // R4, R5: completed result is the wrapped sum of capture-cycle operands
    a_r5_sum_value: assert property (@(posedge clk) disable iff (rst)
        ($rose(ready_out) && !$past(rst) && !$past(rst, 2))
            |-> (sum_out == DATA_W'($past(opa_in, 2) + $past(opb_in, 2))));
endmodule

bind seq_add_unit seq_add_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .go_req    (go_req),
    .opa_in    (opa_in),
    .opb_in    (opb_in),
    .sum_out   (sum_out),
    .ready_out (ready_out)
);

// File: tb/seq_add_unit_tb.sv
module seq_add_unit_tb;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         go_req = 1'b0;
    logic [W-1:0] opa_in = '0;
    logic [W-1:0] opb_in = '0;
    logic [W-1:0] sum_out;
    logic         ready_out;

    int n_vec = 0;
    int n_bad = 0;

    always #10 clk = ~clk;   // 50 MHz

    seq_add_unit #(.DATA_W(W)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .go_req    (go_req),
        .opa_in    (opa_in),
        .opb_in    (opb_in),
        .sum_out   (sum_out),
        .ready_out (ready_out)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one full operation; decoys on the operands outside the capture cycle
    task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W-1:0] exp_s;
        exp_s = W'({1'b0, a} + {1'b0, b});
        @(negedge clk);
        go_req = 1'b1; opa_in = ~a; opb_in = b ^ 16'h5A5A;
        @(negedge clk);                        // in capture
        chk(ready_out == 1'b0, "R3", ready_out, 0);
        go_req = 1'b0; opa_in = a; opb_in = b;
        @(negedge clk);                        // in sum
        chk(ready_out == 1'b0, "R6", ready_out, 0);
        opa_in = a ^ 16'h00FF; opb_in = ~b;
        @(negedge clk);                        // back idle
        chk(ready_out == 1'b1, "R6", ready_out, 1);
        chk(sum_out == exp_s, "R5/R4", sum_out, exp_s);
    endtask

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [W-1:0] held;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk(ready_out == 1'b1, "R1", ready_out, 1);
        chk(sum_out == '0, "R1", sum_out, 0);

        // boundary pairs
        run_op(16'h0000, 16'h0000);
        run_op(16'hFFFF, 16'h0001);
        run_op(16'h8000, 16'h8000);
        run_op(16'hFFFF, 16'hFFFF);
        run_op(16'h7FFF, 16'h0001);
        run_op(16'h1234, 16'h4321);

        // idle stretch with moving inputs: R2, R7
        held = sum_out;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            opa_in = W'(k * 4099); opb_in = W'(~k);
            chk(ready_out == 1'b1, "R2", ready_out, 1);
            chk(sum_out == held, "R7", sum_out, held);
        end

        // back-to-back with go_req held high: R8
        @(negedge clk);
        go_req = 1'b1; opa_in = 16'h1111; opb_in = 16'h2222;
        @(negedge clk); chk(ready_out == 1'b0, "R8", ready_out, 0);
        @(negedge clk); chk(ready_out == 1'b0, "R8", ready_out, 0);
        opa_in = 16'hF000; opb_in = 16'h2000;
        @(negedge clk);
        chk(ready_out == 1'b1, "R8", ready_out, 1);
        chk(sum_out == 16'h3333, "R8", sum_out, 16'h3333);
        @(negedge clk);                        // second op captures now
        chk(ready_out == 1'b0, "R8", ready_out, 0);
        go_req = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(ready_out == 1'b1, "R8", ready_out, 1);
        chk(sum_out == 16'h1000, "R8", sum_out, 16'h1000);

        // reset in the capture cycle: R9
        @(negedge clk);
        go_req = 1'b1; opa_in = 16'h0101; opb_in = 16'h0202;
        @(negedge clk);
        go_req = 1'b0; rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(ready_out == 1'b1, "R9", ready_out, 1);
        chk(sum_out == '0, "R9", sum_out, 0);
        @(negedge clk);
        chk(ready_out == 1'b1, "R9", ready_out, 1);
        chk(sum_out == '0, "R9", sum_out, 0);

        // arithmetic sweep
        for (int i = 0; i < 1024; i++)
            run_op(W'(i * 40503 + 7), W'((i ^ 16'h3C3C) * 2654 + i));

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule